// File: doc/BRIEF.md
# Infrared Carrier Window Demodulator

This block turns a raw infrared receiver input that carries a modulated carrier into a clean mark/space envelope. The envelope feeds a downstream pulse-width timer. A programmable divider turns the reference clock into a sample tick, and a nominal carrier period is 16 ticks. Only rising edges of the pin are timed. After each rising edge the block expects the next one inside an acceptance window around tick 16. The early and the late side of the window can each be widened by one tick.

The envelope goes to mark once the carrier has shown two consecutive in-window periods. It goes back to space when the carrier stops or an edge lands outside the window. When demodulation is switched off, the synchronised pin level is passed through unchanged. Deasserting the enable holds the envelope at space and discards all window tracking.

Top module: `ir_carrier_demod`

## Requirements
- R1: A sample tick occurs once every (div_sel + 1) reference clocks while enabled, so the window limits scale with div_sel. A 16-tick carrier is accepted at any divider value, and a carrier much shorter than 12 ticks is not.
- R2: The rising-edge spacing is accepted when it lies from early to late ticks inclusive. early = 13 - win_sel[0] and late = 19 + win_sel[1], so code 00 accepts 13..19 and code 11 accepts 12..20.
- R3: The first rising edge seen while no window is armed only arms the window and is not counted as a carrier cycle. Two rising edges alone never produce a mark.
- R4: The second consecutive in-window rising edge sets the internal mark. env_out follows it one clock later, and further in-window edges keep it at mark.
- R5: If no rising edge arrives by the late limit, tracking is cleared at the tick where late + 1 ticks have elapsed, and env_out returns to 0 one clock later.
- R6: A rising edge earlier than the early limit, or later than the late limit, is treated as noise. It forces space and re-arms tracking from that edge, so two more in-window edges are needed for mark.
- R7: With demod_en low and enable high, env_out equals ir_raw delayed by three clocks (two synchroniser stages plus the output register).
- R8: With enable low, env_out is 0 from the next clock, and all tick and window state is cleared. The first edge after re-enabling only arms again.
- R9: After reset env_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces space and clears tracking |
| demod_en | input | 1 | 1 = window demodulation, 0 = pass-through of the pin |
| div_sel | input | 16 | Tick divider; tick period is div_sel + 1 clocks |
| win_sel | input | 2 | Window widening: bit 0 early side, bit 1 late side |
| ir_raw | input | 1 | Asynchronous raw infrared input |
| env_out | output | 1 | Envelope, 1 = mark |

## Verification
The assertions assume that div_sel and win_sel change only while enable is low. Under that assumption the checker's own tick count since the last rising edge is a valid bound for how long a mark may last. The stimulus changes configuration only inside a disable interval and applies at least one idle clock before re-enabling. The pin is driven away from clock edges, so the synchroniser delay is an exact three clocks. Carrier bursts are built from whole ticks at the current divider, which keeps edge spacings on the intended side of each window limit.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;

  localparam int NOM_TICKS  = 16;
  localparam int BASE_SLACK = 3;
  localparam int GAP_W      = 6;
  localparam int HIT_W      = 2;
  localparam int HITS_MARK  = 2;

  function automatic logic [GAP_W-1:0] win_early(input logic [1:0] code);
    logic [GAP_W-1:0] base;
    base = GAP_W'(NOM_TICKS - BASE_SLACK);
    return base - {{(GAP_W-1){1'b0}}, code[0]};
  endfunction

  function automatic logic [GAP_W-1:0] win_late(input logic [1:0] code);
    logic [GAP_W-1:0] base;
    base = GAP_W'(NOM_TICKS + BASE_SLACK);
    return base + {{(GAP_W-1){1'b0}}, code[1]};
  endfunction

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ARM   = 2'd1,
    EV_HIT   = 2'd2,
    EV_DROP  = 2'd3
  } edge_kind_e;

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= div_sel);
  assign tick = enable & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enable) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ir_edge_sync.sv
module ir_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic pin,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b0;
          else        sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign level = sh_q[STAGES-1];
  assign rise  = tick & level & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (!enable) begin
      prev_q <= 1'b0;
    end else if (tick) begin
      prev_q <= level;
    end
  end

endmodule

// File: rtl/ir_win_track.sv
module ir_win_track
  import ir_demod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       rise,
  input  logic [1:0] win_sel,
  output logic       mark,
  output logic       ev_arm,
  output logic       ev_hit,
  output logic       ev_drop,
  output logic       ev_expire
);

  logic             armed_q;
  logic [GAP_W-1:0] gap_q;
  logic [HIT_W-1:0] hits_q;
  logic             mark_q;
  logic [GAP_W-1:0] elapsed;
  logic [GAP_W-1:0] lim_lo;
  logic [GAP_W-1:0] lim_hi;
  logic             in_win;
  edge_kind_e       kind;

  assign lim_lo  = win_early(win_sel);
  assign lim_hi  = win_late(win_sel);
  assign elapsed = gap_q + 1'b1;
  assign in_win  = (elapsed >= lim_lo) && (elapsed <= lim_hi);

  always_comb begin
    kind = EV_NONE;
    if (tick && rise) begin
      if (!armed_q)    kind = EV_ARM;
      else if (in_win) kind = EV_HIT;
      else             kind = EV_DROP;
    end
  end

  assign ev_arm    = (kind == EV_ARM);
  assign ev_hit    = (kind == EV_HIT);
  assign ev_drop   = (kind == EV_DROP);
  assign ev_expire = tick & ~rise & armed_q & (elapsed > lim_hi);
  assign mark      = mark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
      hits_q  <= '0;
      mark_q  <= 1'b0;
    end else if (!enable) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
      hits_q  <= '0;
      mark_q  <= 1'b0;
    end else if (tick) begin
      unique case (kind)
        EV_ARM: begin
          armed_q <= 1'b1;
          gap_q   <= '0;
          hits_q  <= '0;
        end
        EV_HIT: begin
          gap_q <= '0;
          if (hits_q >= HIT_W'(HITS_MARK - 1)) mark_q <= 1'b1;
          if (hits_q < HIT_W'(HITS_MARK))      hits_q <= hits_q + 1'b1;
        end
        EV_DROP: begin
          armed_q <= 1'b1;
          gap_q   <= '0;
          hits_q  <= '0;
          mark_q  <= 1'b0;
        end
        default: begin
          if (ev_expire) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
            hits_q  <= '0;
            mark_q  <= 1'b0;
          end else if (armed_q) begin
            gap_q <= elapsed;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod #(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             demod_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       win_sel,
  input  logic             ir_raw,
  output logic             env_out
);

  logic tick_w;
  logic level_w;
  logic rise_w;
  logic mark_w;
  logic ev_arm_w;
  logic ev_hit_w;
  logic ev_drop_w;
  logic ev_expire_w;
  logic env_q;

  ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .div_sel (div_sel),
    .tick    (tick_w)
  );

  ir_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .tick   (tick_w),
    .pin    (ir_raw),
    .level  (level_w),
    .rise   (rise_w)
  );

  ir_win_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick_w),
    .rise      (rise_w),
    .win_sel   (win_sel),
    .mark      (mark_w),
    .ev_arm    (ev_arm_w),
    .ev_hit    (ev_hit_w),
    .ev_drop   (ev_drop_w),
    .ev_expire (ev_expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        env_q <= 1'b0;
    else if (!enable)  env_q <= 1'b0;
    else if (demod_en) env_q <= mark_w;
    else               env_q <= level_w;
  end

  assign env_out = env_q;

endmodule

// File: rtl/ir_demod_chk.sv
module ir_demod_chk
  import ir_demod_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             demod_en,
  input logic [DIV_W-1:0] div_sel,
  input logic [1:0]       win_sel,
  input logic             ir_raw,
  input logic             env_out,
  input logic             tick,
  input logic             rise,
  input logic             mark,
  input logic             ev_arm,
  input logic             ev_hit,
  input logic             ev_drop,
  input logic             ev_expire
);

  logic [7:0] since_q;
  logic [2:0] up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      up_q    <= '0;
    end else begin
      if (up_q != 3'd7) up_q <= up_q + 1'b1;
      if (!enable || rise)                 since_q <= '0;
      else if (tick && since_q != 8'hFF)   since_q <= since_q + 1'b1;
    end
  end

  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div_sel != '0) && $stable(div_sel) |=> !tick);

  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_arm, ev_hit, ev_drop, ev_expire}));

  p_arm_no_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> !mark);

  p_mark_from_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mark) |-> $past(ev_hit));

  p_late_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> since_q <= {2'b00, win_late(win_sel)});

  p_noise_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !mark);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !demod_en && (up_q >= 3'd3) |=> env_out == $past(ir_raw, 3));

  p_idle_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !env_out && !mark);

endmodule

bind ir_carrier_demod ir_demod_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .demod_en  (demod_en),
  .div_sel   (div_sel),
  .win_sel   (win_sel),
  .ir_raw    (ir_raw),
  .env_out   (env_out),
  .tick      (tick_w),
  .rise      (rise_w),
  .mark      (mark_w),
  .ev_arm    (ev_arm_w),
  .ev_hit    (ev_hit_w),
  .ev_drop   (ev_drop_w),
  .ev_expire (ev_expire_w)
);

// File: tb/ir_carrier_demod_tb_top.sv
module ir_carrier_demod_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        demod_en = 1'b1;
  logic [15:0] div_sel = 16'd1;
  logic [1:0]  win_sel = 2'b00;
  logic        ir_raw = 1'b0;
  logic        env_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R9";

  always #10 clk = ~clk;

  ir_carrier_demod dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .demod_en (demod_en),
    .div_sel  (div_sel),
    .win_sel  (win_sel),
    .ir_raw   (ir_raw),
    .env_out  (env_out)
  );

  // Behavioural reference: integer state, recomputed at every clock edge.
  int m_s1, m_s2, m_prev, m_cnt, m_gap, m_hits, m_env;
  bit m_armed, m_mark;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0; m_gap = 0;
      m_hits = 0; m_env = 0; m_armed = 0; m_mark = 0;
    end else begin
      bit tk, rs;
      int el, lo, hi;
      tk = enable && (m_cnt >= int'(div_sel));
      rs = tk && (m_s2 == 1) && (m_prev == 0);
      m_env = !enable ? 0 : (demod_en ? int'(m_mark) : m_s2);
      lo = 13 - int'(win_sel[0]);
      hi = 19 + int'(win_sel[1]);
      if (!enable) begin
        m_armed = 0; m_gap = 0; m_hits = 0; m_mark = 0;
      end else if (tk) begin
        el = m_gap + 1;
        if (rs) begin
          if (!m_armed) begin
            m_armed = 1; m_gap = 0; m_hits = 0;
          end else if (el < lo || el > hi) begin
            m_gap = 0; m_hits = 0; m_mark = 0;
          end else begin
            m_gap = 0;
            m_hits = m_hits + 1;
            if (m_hits >= 2) begin m_mark = 1; m_hits = 2; end
          end
        end else if (m_armed) begin
          if (el > hi) begin
            m_armed = 0; m_gap = 0; m_hits = 0; m_mark = 0;
          end else m_gap = el;
        end
      end
      if (!enable) begin m_cnt = 0; m_prev = 0; end
      else begin
        if (tk) m_prev = m_s2;
        m_cnt = tk ? 0 : m_cnt + 1;
      end
      m_s2 = m_s1;
      m_s1 = int'(ir_raw);
    end
  end

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(env_out) != m_env) begin
        errors++;
        $display("FAIL %s model compare at cycle %0d: env_out=%0d expected=%0d",
                 phase, cycles, env_out, m_env);
      end
    end
  end

  task automatic expect_env(input logic exp, input string req);
    checks++;
    if (env_out !== exp) begin
      errors++;
      $display("FAIL %s directed check: env_out=%0d expected=%0d", req, env_out, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * (int'(div_sel) + 1)) @(negedge clk);
  endtask

  task automatic pulse(input int hi_t, input int lo_t);
    ir_raw = 1'b1; wait_ticks(hi_t);
    ir_raw = 1'b0; wait_ticks(lo_t);
  endtask

  task automatic burst(input int n, input int period);
    for (int i = 0; i < n; i++) pulse(4, period - 4);
  endtask

  task automatic reconfig(input int dv, input logic [1:0] code, input logic dm);
    enable = 1'b0; ir_raw = 1'b0;
    repeat (3) @(negedge clk);
    div_sel = 16'(dv); win_sel = code; demod_en = dm;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: done=0 expected=1", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_env(1'b0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    expect_env(1'b0, "R9");

    // R4/R1/R5: nominal carrier at divider 1, code 00
    phase = "R4"; reconfig(1, 2'b00, 1'b1);
    burst(6, 16);
    expect_env(1'b1, "R4");
    phase = "R5"; wait_ticks(23);
    expect_env(1'b0, "R5");

    // R3: two edges only arm and count once
    phase = "R3"; reconfig(1, 2'b00, 1'b1);
    burst(2, 16);
    expect_env(1'b0, "R3");
    burst(1, 16);
    expect_env(1'b1, "R3");
    wait_ticks(25);

    // R2: early side
    phase = "R2"; reconfig(1, 2'b00, 1'b1);
    burst(6, 12);
    expect_env(1'b0, "R2");
    reconfig(1, 2'b01, 1'b1);
    burst(6, 12);
    expect_env(1'b1, "R2");
    wait_ticks(25);

    // R2: late side
    reconfig(1, 2'b00, 1'b1);
    burst(6, 20);
    expect_env(1'b0, "R2");
    reconfig(1, 2'b10, 1'b1);
    burst(6, 20);
    expect_env(1'b1, "R2");
    wait_ticks(25);

    // R6: early noise edge drops mark and restarts tracking
    phase = "R6"; reconfig(1, 2'b00, 1'b1);
    burst(4, 16);
    pulse(2, 4);
    expect_env(1'b1, "R6");
    pulse(2, 14);
    expect_env(1'b0, "R6");
    pulse(4, 12);
    expect_env(1'b0, "R6");
    pulse(4, 12);
    expect_env(1'b1, "R6");
    wait_ticks(25);

    // R1: different divider keeps the window in ticks
    phase = "R1"; reconfig(2, 2'b00, 1'b1);
    burst(5, 16);
    expect_env(1'b1, "R1");
    wait_ticks(25);
    expect_env(1'b0, "R1");
    burst(6, 10);
    expect_env(1'b0, "R1");
    wait_ticks(25);

    // R8: enable low clears envelope and tracking
    phase = "R8"; reconfig(1, 2'b00, 1'b1);
    burst(5, 16);
    expect_env(1'b1, "R8");
    enable = 1'b0;
    repeat (2) @(negedge clk);
    expect_env(1'b0, "R8");
    enable = 1'b1;
    burst(2, 16);
    expect_env(1'b0, "R8");
    wait_ticks(25);

    // R7: pass-through with demodulation off
    phase = "R7"; reconfig(1, 2'b00, 1'b0);
    ir_raw = 1'b1;
    repeat (2) @(negedge clk);
    expect_env(1'b0, "R7");
    @(negedge clk);
    expect_env(1'b1, "R7");
    ir_raw = 1'b0;
    repeat (4) @(negedge clk);
    expect_env(1'b0, "R7");
    burst(3, 7);

    enable = 1'b0;
    repeat (2) @(negedge clk);
    expect_env(1'b0, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule